// File: doc/BRIEF.md
# UART Buffering and Interrupt Core

This block is the character-buffering and status part of a 16550-style UART. It has a transmit queue and a receive queue of 16 characters each. A register port sets up the queues, the interrupt enables and the modem controls. Through the same port, a host can push characters to transmit, pop received characters, and read a line-status byte and an interrupt-identification byte. The serial shifter lives outside this block. It takes characters from the transmit queue through a valid/take handshake and drops received characters in with a one-cycle push strobe.

A receive interrupt is raised when the receive queue holds at least a programmable number of characters: 1, 4, 8 or 14. The interrupt-identification code ranks three sources. Line status comes first, then received data, then an empty transmit queue. Flow control is done in hardware. With automatic RTS, `rts_n` goes high while the receive queue is at or above its trigger depth. With automatic CTS, a high `cts_n` holds back the next character. A character the shifter has already taken still finishes.

Register map (3-bit address): 0 = data (a write pushes to the transmit queue, a read pops the receive queue), 1 = interrupt enable, 2 = queue control on write and interrupt identification on read, 3 = modem control, 4 = line status. All reads are combinational in the cycle `reg_rd` is high. Their side effects take place at the next clock edge.

Top module: `uart_fifo_core`

## Requirements
- R1: After reset, line status reads 0x60 and interrupt identification reads 0x01. `irq`, `tx_valid` and `rts_n` (which reads 1) are all inactive.
- R2: Both queues are first-in first-out. With queue control bit 0 set, each queue holds 16 characters. With bit 0 clear, each holds one.
- R3: A data write to a full transmit queue is dropped and sets line-status bit 7. A receive push into a full queue is dropped and sets bit 1. Both bits are sticky until line status is read.
- R4: Writing queue control with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue. Neither bit is stored, so later pushes work normally.
- R5: Queue control bits 7:6 select the receive trigger depth: 0→1, 1→4, 2→8, 3→14. With enable bit 0 set, interrupt identification reads 0x04 and `irq` is 1 while the receive count is at or above that depth.
- R6: With enable bit 1 set and the transmit queue empty, interrupt identification reads 0x02 and `irq` is 1.
- R7: Identification bits 3:1 carry the highest pending source: 3 for line status (enable bit 2 with bit 1 of line status set), then 2, then 1. Bit 0 reads 1 when nothing is pending.
- R8: Line status bit 0 reads 1 when a received character is waiting. Bit 5 reads 1 when the transmit queue is empty. Bit 6 reads 1 when it is empty and `tx_busy` is low.
- R9: With modem-control bit 6 set, `rts_n` is 1 while the receive count is at or above the trigger depth and 0 below it. With bit 6 clear, `rts_n` is the inverse of modem-control bit 1.
- R10: With modem-control bit 7 set and `cts_n` high, `tx_valid` is 0 and nothing leaves the transmit queue. With bit 7 clear, `cts_n` has no effect.
- R11: A data read with the receive queue empty returns the last character popped and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high |
| rx_push | input | 1 | Received character strobe from the shifter |
| rx_char | input | 8 | Received character |
| tx_valid | output | 1 | A character is offered to the shifter |
| tx_char | output | 8 | Offered character |
| tx_take | input | 1 | Shifter accepts the offered character |
| tx_busy | input | 1 | Shifter is still sending |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Interrupt request |

## Verification
A wrong queue pointer or count shows up at once in the order of characters at `tx_char` and in read data. It also shows as line-status bits 0 and 5, or as identification codes that disagree with the number of characters pushed. A trigger decode that is off by one moves the edge of `irq` and `rts_n` by exactly one push, so the bench checks both sides of each depth. A sticky flag that is set or cleared wrongly appears on the next line-status read or identification read.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IEN  = 3'd1;
  localparam logic [2:0] A_QCTL = 3'd2;
  localparam logic [2:0] A_MCTL = 3'd3;
  localparam logic [2:0] A_LSTS = 3'd4;

  // Receive trigger depth from the select field; one when queues are disabled
  function automatic int unsigned rx_threshold(input logic en, input logic [1:0] sel);
    if (!en) return 1;
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [7:0] pack_ident(input logic [2:0] code, input logic none);
    return {4'b0000, code, none};
  endfunction
endpackage

// File: rtl/uart_char_queue.sv
module uart_char_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= din;
  end

  assign dout = mem[rp];
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio (
  input  logic       ls_req,
  input  logic       rx_req,
  input  logic       tx_req,
  output logic [2:0] code,
  output logic       none
);
  always_comb begin
    none = 1'b0;
    if (ls_req)      code = 3'd3;
    else if (rx_req) code = 3'd2;
    else if (tx_req) code = 3'd1;
    else begin
      code = 3'd0;
      none = 1'b1;
    end
  end
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_push,
  input  logic [7:0] rx_char,
  output logic       tx_valid,
  output logic [7:0] tx_char,
  input  logic       tx_take,
  input  logic       tx_busy,
  input  logic       cts_n,
  output logic       rts_n,
  output logic       irq
);
  import uart_fifo_pkg::*;

  logic          q_en;
  logic [1:0]    trig_sel;
  logic [2:0]    ien;
  logic [7:0]    mctl;
  logic          tx_ovf, rx_ovr;
  logic [7:0]    last_rx;
  logic [CW-1:0] tx_cnt, rx_cnt, cap, trig;
  logic [7:0]    rx_head, lsts;
  logic          tx_full, rx_full, tx_empty, trig_hit;
  logic          qctl_wr, tx_clr, rx_clr, host_tx_wr, tx_push, tx_drop, tx_pop;
  logic          rx_pop, rx_in, rx_lost, lsts_rd;
  logic [2:0]    id_code;
  logic          id_none;

  // Named internal events
  assign cap        = q_en ? CW'(DEPTH) : CW'(1);
  assign trig       = CW'(rx_threshold(q_en, trig_sel));
  assign tx_full    = tx_cnt >= cap;
  assign rx_full    = rx_cnt >= cap;
  assign tx_empty   = tx_cnt == '0;
  assign trig_hit   = rx_cnt >= trig;
  assign qctl_wr    = reg_wr && reg_addr == A_QCTL;
  assign tx_clr     = qctl_wr && reg_wdata[2];
  assign rx_clr     = qctl_wr && reg_wdata[1];
  assign host_tx_wr = reg_wr && reg_addr == A_DATA;
  assign tx_push    = host_tx_wr && !tx_full;
  assign tx_drop    = host_tx_wr && tx_full;
  assign tx_valid   = !tx_empty && !(mctl[7] && cts_n);
  assign tx_pop     = tx_valid && tx_take;
  assign rx_pop     = reg_rd && reg_addr == A_DATA && rx_cnt != '0;
  assign rx_in      = rx_push && !rx_full;
  assign rx_lost    = rx_push && rx_full;
  assign lsts_rd    = reg_rd && reg_addr == A_LSTS;

  uart_char_queue #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
    .din(reg_wdata), .dout(tx_char), .count(tx_cnt)
  );

  uart_char_queue #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_in), .pop(rx_pop),
    .din(rx_char), .dout(rx_head), .count(rx_cnt)
  );

  uart_irq_prio u_prio (
    .ls_req(ien[2] && rx_ovr),
    .rx_req(ien[0] && trig_hit),
    .tx_req(ien[1] && tx_empty),
    .code(id_code),
    .none(id_none)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_en     <= 1'b0;
      trig_sel <= 2'd0;
      ien      <= 3'd0;
      mctl     <= 8'd0;
      tx_ovf   <= 1'b0;
      rx_ovr   <= 1'b0;
      last_rx  <= 8'd0;
    end else begin
      if (qctl_wr) begin
        q_en     <= reg_wdata[0];
        trig_sel <= reg_wdata[7:6];
      end
      if (reg_wr && reg_addr == A_IEN)  ien  <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_MCTL) mctl <= reg_wdata;
      if (tx_drop)      tx_ovf <= 1'b1;
      else if (lsts_rd) tx_ovf <= 1'b0;
      if (rx_lost)      rx_ovr <= 1'b1;
      else if (lsts_rd) rx_ovr <= 1'b0;
      if (rx_pop) last_rx <= rx_head;
    end
  end

  assign lsts  = {tx_ovf, tx_empty && !tx_busy, tx_empty, 3'b000, rx_ovr, rx_cnt != '0};
  assign rts_n = mctl[6] ? trig_hit : ~mctl[1];
  assign irq   = !id_none;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = (rx_cnt != '0) ? rx_head : last_rx;
      A_IEN:   reg_rdata = {5'b00000, ien};
      A_QCTL:  reg_rdata = pack_ident(id_code, id_none);
      A_MCTL:  reg_rdata = mctl;
      A_LSTS:  reg_rdata = lsts;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_fifo_core_chk.sv
module uart_fifo_core_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_drop,
  input logic          tx_ovf,
  input logic          rx_push,
  input logic          tx_valid,
  input logic          cts_n,
  input logic [7:0]    mctl,
  input logic [2:0]    ien,
  input logic          rts_n,
  input logic          irq
);
  AST_TXQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));  // R2
  AST_RXQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));  // R2
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> tx_ovf);  // R3
  AST_THRE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[1] && tx_cnt == '0) |-> irq);  // R6
  AST_RTS_LOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mctl[6] && rx_cnt == '0) |-> !rts_n);  // R9
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mctl[7] && cts_n) |-> !tx_valid);  // R10
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);  // R11
endmodule

bind uart_fifo_core uart_fifo_core_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_drop(tx_drop), .tx_ovf(tx_ovf),
  .rx_push(rx_push), .tx_valid(tx_valid), .cts_n(cts_n), .mctl(mctl),
  .ien(ien), .rts_n(rts_n), .irq(irq)
);

// File: tb/uart_fifo_core_bench.sv
module uart_fifo_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic rx_push = 0;
  logic [7:0] rx_char = 0;
  logic tx_valid, tx_take = 0, tx_busy = 0, cts_n = 0, rts_n, irq;
  logic [7:0] tx_char;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_fifo_core u_uart_fifo_core (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_char(rx_char),
    .tx_valid(tx_valid), .tx_char(tx_char), .tx_take(tx_take), .tx_busy(tx_busy),
    .cts_n(cts_n), .rts_n(rts_n), .irq(irq)
  );

  // {trigger select[1:0], pushes[4:0], expected ident[7:0], expected rts_n}
  localparam logic [15:0] VEC [9] = '{
    {2'd0, 5'd0,  8'h01, 1'b0}, {2'd0, 5'd1,  8'h04, 1'b1},
    {2'd1, 5'd3,  8'h01, 1'b0}, {2'd1, 5'd4,  8'h04, 1'b1},
    {2'd2, 5'd7,  8'h01, 1'b0}, {2'd2, 5'd8,  8'h04, 1'b1},
    {2'd3, 5'd13, 8'h01, 1'b0}, {2'd3, 5'd14, 8'h04, 1'b1},
    {2'd3, 5'd16, 8'h04, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rxp(input logic [7:0] c);
    @(negedge clk); rx_push = 1; rx_char = c;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic take(input string tag, input logic [7:0] exp);
    @(negedge clk); check(tag, tx_char, exp); tx_take = 1;
    @(negedge clk); tx_take = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd4, v); check("R1 lsts", v, 8'h60);
    rd(3'd2, v); check("R1 ident", v, 8'h01);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 rts_n", {7'd0, rts_n}, 8'd1);
    check("R1 tx_valid", {7'd0, tx_valid}, 8'd0);

    // R5 / R9 trigger depth table, auto RTS on, receive enable only
    wr(3'd1, 8'h01); wr(3'd3, 8'h40);
    for (int i = 0; i < 9; i++) begin
      wr(3'd2, {VEC[i][15:14], 6'b000011});
      for (int k = 0; k < int'(VEC[i][13:9]); k++) rxp(8'(k));
      rd(3'd2, v); check("R5 ident", v, VEC[i][8:1]);
      check("R9 rts_n", {7'd0, rts_n}, {7'd0, VEC[i][0]});
    end
    // R9 drain below depth 4
    wr(3'd2, 8'h43); for (int k = 0; k < 4; k++) rxp(8'(k));
    check("R9 at depth", {7'd0, rts_n}, 8'd1);
    rd(3'd0, v); check("R2 rx first", v, 8'h00);
    check("R9 below depth", {7'd0, rts_n}, 8'd0);
    // R9 manual mode
    wr(3'd3, 8'h02); check("R9 manual on", {7'd0, rts_n}, 8'd0);
    wr(3'd3, 8'h00); check("R9 manual off", {7'd0, rts_n}, 8'd1);
    wr(3'd1, 8'h00);

    // R2 / R3 transmit order and overflow
    wr(3'd2, 8'h07);
    for (int k = 0; k < 16; k++) wr(3'd0, 8'h30 + 8'(k));
    rd(3'd4, v); check("R8 tx not empty", v, 8'h00);
    wr(3'd0, 8'hEE);
    rd(3'd4, v); check("R3 ovf set", v, 8'h80);
    rd(3'd4, v); check("R3 ovf cleared", v, 8'h00);
    for (int k = 0; k < 16; k++) take("R2 tx order", 8'h30 + 8'(k));
    check("R3 dropped not queued", {7'd0, tx_valid}, 8'd0);

    // R2 single-entry mode
    wr(3'd2, 8'h06);
    wr(3'd0, 8'hA1); wr(3'd0, 8'hA2);
    rd(3'd4, v); check("R2 cap one", v, 8'h80);
    take("R2 cap one char", 8'hA1);
    check("R2 cap one empty", {7'd0, tx_valid}, 8'd0);

    // R4 clears
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h11); rxp(8'h22);
    rd(3'd4, v); check("R8 both busy", v, 8'h01);
    wr(3'd2, 8'h07);
    rd(3'd4, v); check("R4 cleared", v, 8'h60);
    wr(3'd0, 8'h33); take("R4 push after clear", 8'h33);

    // R6 transmit-empty interrupt
    wr(3'd1, 8'h02);
    rd(3'd2, v); check("R6 ident", v, 8'h02);
    check("R6 irq", {7'd0, irq}, 8'd1);
    wr(3'd3, 8'h80); cts_n = 1;
    wr(3'd0, 8'h44);
    rd(3'd2, v); check("R6 ident off", v, 8'h01);
    // R10 auto CTS
    check("R10 held", {7'd0, tx_valid}, 8'd0);
    @(negedge clk); cts_n = 0; #1;
    check("R10 released", {7'd0, tx_valid}, 8'd1);
    wr(3'd3, 8'h00); cts_n = 1; #1;
    check("R10 no effect", {7'd0, tx_valid}, 8'd1);
    cts_n = 0;
    take("R10 char", 8'h44);

    // R8 busy shifter
    tx_busy = 1;
    rd(3'd4, v); check("R8 busy", v, 8'h20);
    tx_busy = 0;
    rd(3'd4, v); check("R8 idle", v, 8'h60);

    // R7 priority
    wr(3'd1, 8'h07); wr(3'd2, 8'h07);
    for (int k = 0; k < 17; k++) rxp(8'h50 + 8'(k));
    rd(3'd2, v); check("R7 line status", v, 8'h06);
    rd(3'd4, v); check("R3 rx overrun", v, 8'h63);
    rd(3'd2, v); check("R7 rx data", v, 8'h04);
    wr(3'd2, 8'h03);
    rd(3'd2, v); check("R7 tx empty", v, 8'h02);
    wr(3'd1, 8'h00);
    rd(3'd2, v); check("R7 none", v, 8'h01);

    // R11 empty read
    rxp(8'h5A);
    rd(3'd0, v); check("R11 read", v, 8'h5A);
    rd(3'd0, v); check("R11 empty read", v, 8'h5A);
    rd(3'd4, v); check("R11 state", v, 8'h60);
    rxp(8'h11);
    rd(3'd0, v); check("R11 next", v, 8'h11);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule